// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of interrupt request lines, forms the pending set, and keeps only the pending lines whose priority lies strictly above the current threshold. From those lines it selects the highest-numbered one. The winner's index selects a handler address from a writable vector table. When the global enable is set, the controller hands that address to the core with a registered one-cycle take strobe.

Taking an interrupt does three things: it clears the global enable, it raises the threshold to the taken line's priority, and it pushes the old threshold onto a bounded level stack. Software in the handler can set the enable again. After that, only a strictly higher line can preempt, and it nests one level deeper. A return handshake pops one level.

Lines marked as edge-captured keep a sticky pending bit, so an edge that arrives while the controller is masked is still kept.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Line k has priority k+1. Among the eligible lines, the highest-numbered one wins and is reported on `irq_idx`.
- R2: `vec_sel`/`vec_wdata` with `vec_wr` write entry k of the vector table. When line k is taken, `vec_addr` shows entry k in the same cycle as `take`.
- R3: `take` is raised only at a clock edge where the global enable was 1 beforehand. `gie_set` sets the enable and `gie_clr` clears it.
- R4: In the cycle `take` is high, `gie` is 0 and `cur_thr` equals the taken index plus one.
- R5: A pending line is eligible only when its priority is strictly greater than `cur_thr`. `thr_wr` loads `cur_thr` from `thr_wdata`.
- R6: With the default `EDGE_LINES` = 8'hF0, lines 4 to 7 are edge-captured. On these lines, a rising input sets bit k of `pending`, even while the enable is 0. The bit stays set until `pend_clr[k]` is written. Lines 0 to 3 follow their input level.
- R7: Each take increments `depth` by one. A `ret` with `depth` > 0 decrements `depth`, restores the threshold saved at that take, and sets `gie`. A `ret` at depth 0 changes nothing.
- R8: While `depth` equals `STACK_DEPTH`, no take occurs, even if the enable is set and a line is eligible.
- R9: `take` lasts exactly one cycle. No further take occurs until `ack` has been seen.
- R10: With no eligible line, `irq_valid` is 0 and `irq_idx` is 0.
- R11: After reset, `take`, `gie`, `cur_thr`, `depth`, `pending` and `irq_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Request lines |
| pend_clr | input | NUM_IRQ | Clear strobes for sticky pending bits |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | LVL_W | Threshold write value |
| vec_wr | input | 1 | Vector table write strobe |
| vec_sel | input | IDX_W | Vector table entry to write |
| vec_wdata | input | ADDR_W | Handler address to write |
| ack | input | 1 | Core acknowledges a take |
| ret | input | 1 | Core returns from a handler |
| irq_valid | output | 1 | An eligible line exists |
| irq_idx | output | IDX_W | Winning line index |
| take | output | 1 | One-cycle take strobe |
| vec_addr | output | ADDR_W | Handler address of the taken line |
| gie | output | 1 | Global enable state |
| cur_thr | output | LVL_W | Current threshold |
| depth | output | DEPTH_W | Nesting depth |
| pending | output | NUM_IRQ | Pending set |

## Verification
The bench targets an edge that arrives while the enable is clear. A controller without capture would lose it, and the later enable would produce no take.

It presents a higher line before the first take is acknowledged. A design that ignores the handshake would issue a second take at once.

It checks the boundary where a line's priority equals the threshold. An off-by-one compare would let that line through.

It fills the nesting stack and then presents a higher line. A design without a full guard would overwrite the saved threshold, and later returns would restore the wrong levels. The bench also checks that a return at depth 0 does not underflow.

// File: rtl/nic_pkg.sv
package nic_pkg;
   // ceiling log2, never below one bit
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned r;
      r = 1;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/nic_pend.sv
module nic_pend #(
   parameter int unsigned N = 8,
   parameter logic [N-1:0] EDGE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   for (genvar k = 0; k < N; k++) begin : g_line
      if (EDGE[k]) begin : g_edge
         logic prev_q;
         logic sticky_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q   <= 1'b0;
               sticky_q <= 1'b0;
            end else begin
               prev_q   <= irq_in[k];
               sticky_q <= (sticky_q & ~clr[k]) | (irq_in[k] & ~prev_q);
            end
         end
         assign pend[k] = sticky_q;
      end else begin : g_level
         assign pend[k] = irq_in[k];
      end
   end
endmodule

// File: rtl/nic_pick.sv
module nic_pick #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3,
   parameter int unsigned LW = 4
) (
   input  logic [N-1:0]  pend,
   input  logic [LW-1:0] thr,
   output logic          found,
   output logic [IW-1:0] win
);
   logic [N-1:0] elig;

   for (genvar k = 0; k < N; k++) begin : g_elig
      assign elig[k] = pend[k] && (LW'(k + 1) > thr);
   end

   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (!found && elig[k]) begin
            found = 1'b1;
            win   = IW'(k);
         end
      end
   end
endmodule

// File: rtl/nic_vtab.sv
module nic_vtab #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3,
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] wsel,
   input  logic [AW-1:0] wdata,
   input  logic [IW-1:0] rsel,
   output logic [AW-1:0] rdata
);
   logic [AW-1:0] ent_q [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) ent_q[k] <= '0;
      end else if (wr && (32'(wsel) < N)) begin
         ent_q[wsel] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N; k++)
         if (32'(rsel) == k) rdata = ent_q[k];
   end
endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned LW    = 4,
   parameter int unsigned DW    = 3,
   parameter int unsigned SAW   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [LW-1:0] push_val,
   output logic [LW-1:0] top_val,
   output logic [DW-1:0] level,
   output logic          full
);
   logic [LW-1:0] mem_q [DEPTH];
   logic [DW-1:0] lvl_q;
   logic [DW-1:0] lvl_m1;

   assign lvl_m1 = lvl_q - 1'b1;
   assign full   = (32'(lvl_q) == DEPTH);
   assign level  = lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      end else if (pop && lvl_q != '0) begin
         lvl_q <= lvl_m1;
      end else if (push && !full) begin
         mem_q[lvl_q[SAW-1:0]] <= push_val;
         lvl_q <= lvl_q + 1'b1;
      end
   end

   assign top_val = (lvl_q == '0) ? '0 : mem_q[lvl_m1[SAW-1:0]];
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int unsigned NUM_IRQ     = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned STACK_DEPTH = 4,
   parameter logic [NUM_IRQ-1:0] EDGE_LINES = 8'hF0,
   localparam int unsigned IDX_W   = nic_pkg::bits_for(NUM_IRQ),
   localparam int unsigned LVL_W   = nic_pkg::bits_for(NUM_IRQ + 1),
   localparam int unsigned DEPTH_W = nic_pkg::bits_for(STACK_DEPTH + 1),
   localparam int unsigned SAW     = nic_pkg::bits_for(STACK_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [NUM_IRQ-1:0] pend_clr,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               thr_wr,
   input  logic [LVL_W-1:0]   thr_wdata,
   input  logic               vec_wr,
   input  logic [IDX_W-1:0]   vec_sel,
   input  logic [ADDR_W-1:0]  vec_wdata,
   input  logic               ack,
   input  logic               ret,
   output logic               irq_valid,
   output logic [IDX_W-1:0]   irq_idx,
   output logic               take,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               gie,
   output logic [LVL_W-1:0]   cur_thr,
   output logic [DEPTH_W-1:0] depth,
   output logic [NUM_IRQ-1:0] pending
);
   if (NUM_IRQ < 2) begin : g_bad_n
      $error("NUM_IRQ must be at least 2");
   end
   if (STACK_DEPTH < 1) begin : g_bad_d
      $error("STACK_DEPTH must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_a
      $error("ADDR_W must be at least 1");
   end

   logic               take_q, busy_q, gie_q;
   logic [ADDR_W-1:0]  vec_q;
   logic [LVL_W-1:0]   thr_q;
   logic [ADDR_W-1:0]  tab_rd;
   logic [LVL_W-1:0]   saved_thr;
   logic               stk_full, take_go, do_pop;

   nic_pend #(.N(NUM_IRQ), .EDGE(EDGE_LINES)) i_pend (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(pend_clr), .pend(pending)
   );

   nic_pick #(.N(NUM_IRQ), .IW(IDX_W), .LW(LVL_W)) i_pick (
      .pend(pending), .thr(thr_q), .found(irq_valid), .win(irq_idx)
   );

   nic_vtab #(.N(NUM_IRQ), .IW(IDX_W), .AW(ADDR_W)) i_vtab (
      .clk(clk), .rst_n(rst_n), .wr(vec_wr), .wsel(vec_sel), .wdata(vec_wdata),
      .rsel(irq_idx), .rdata(tab_rd)
   );

   assign do_pop  = ret && (depth != '0);
   assign take_go = irq_valid && gie_q && !busy_q && !stk_full && !ret;

   nic_stack #(.DEPTH(STACK_DEPTH), .LW(LVL_W), .DW(DEPTH_W), .SAW(SAW)) i_stack (
      .clk(clk), .rst_n(rst_n), .push(take_go), .pop(do_pop), .push_val(thr_q),
      .top_val(saved_thr), .level(depth), .full(stk_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         busy_q <= 1'b0;
         gie_q  <= 1'b0;
         thr_q  <= '0;
         vec_q  <= '0;
      end else begin
         take_q <= take_go;
         if (take_go) vec_q <= tab_rd;
         if (take_go)  busy_q <= 1'b1;
         else if (ack) busy_q <= 1'b0;
         if (do_pop) begin
            thr_q <= saved_thr;
            gie_q <= 1'b1;
         end else if (take_go) begin
            thr_q <= LVL_W'(irq_idx) + 1'b1;
            gie_q <= 1'b0;
         end else begin
            if (thr_wr) thr_q <= thr_wdata;
            if (gie_set)      gie_q <= 1'b1;
            else if (gie_clr) gie_q <= 1'b0;
         end
      end
   end

   assign take     = take_q;
   assign vec_addr = vec_q;
   assign gie      = gie_q;
   assign cur_thr  = thr_q;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
   parameter int unsigned NUM_IRQ     = 8,
   parameter int unsigned STACK_DEPTH = 4,
   parameter logic [NUM_IRQ-1:0] EDGE_LINES = '0,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned LVL_W   = 4,
   parameter int unsigned DEPTH_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] pend_clr,
   input logic               ack,
   input logic               irq_valid,
   input logic [IDX_W-1:0]   irq_idx,
   input logic               take,
   input logic               gie,
   input logic [LVL_W-1:0]   cur_thr,
   input logic [DEPTH_W-1:0] depth,
   input logic [NUM_IRQ-1:0] pending
);
   assert_take_needs_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(take) |-> $past(gie));
   assert_take_clears_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !gie);
   assert_above_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (LVL_W'($past(irq_idx)) + 1'b1 > $past(cur_thr)));
   assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pending) & ~$past(pend_clr) & EDGE_LINES & ~pending) == '0));
   assert_nest_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (depth == $past(depth) + 1'b1));
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(depth) <= STACK_DEPTH);
   assert_one_cycle_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);
   assert_idle_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_idx == '0));
endmodule

bind nest_irq_ctrl nic_chk #(
   .NUM_IRQ(NUM_IRQ), .STACK_DEPTH(STACK_DEPTH), .EDGE_LINES(EDGE_LINES),
   .IDX_W(IDX_W), .LVL_W(LVL_W), .DEPTH_W(DEPTH_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .pend_clr(pend_clr), .ack(ack), .irq_valid(irq_valid),
   .irq_idx(irq_idx), .take(take), .gie(gie), .cur_thr(cur_thr), .depth(depth),
   .pending(pending)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   irq_in = '0, pend_clr = '0;
   logic         gie_set = 0, gie_clr = 0, thr_wr = 0, vec_wr = 0, ack = 0, ret = 0;
   logic [3:0]   thr_wdata = '0;
   logic [2:0]   vec_sel = '0;
   logic [15:0]  vec_wdata = '0;
   logic         irq_valid, take, gie;
   logic [2:0]   irq_idx;
   logic [15:0]  vec_addr;
   logic [3:0]   cur_thr;
   logic [1:0]   depth;
   logic [7:0]   pending;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nest_irq_ctrl #(.NUM_IRQ(8), .ADDR_W(16), .STACK_DEPTH(2), .EDGE_LINES(8'hF0)) i_nest_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pend_clr(pend_clr), .gie_set(gie_set),
      .gie_clr(gie_clr), .thr_wr(thr_wr), .thr_wdata(thr_wdata), .vec_wr(vec_wr),
      .vec_sel(vec_sel), .vec_wdata(vec_wdata), .ack(ack), .ret(ret),
      .irq_valid(irq_valid), .irq_idx(irq_idx), .take(take), .vec_addr(vec_addr),
      .gie(gie), .cur_thr(cur_thr), .depth(depth), .pending(pending)
   );

   // {lines[15:8], threshold[7:4], valid[3], index[2:0]}
   localparam logic [15:0] PICK_VEC [10] = '{
      {8'h00, 4'd0, 1'b0, 3'd0},
      {8'h01, 4'd0, 1'b1, 3'd0},
      {8'h81, 4'd0, 1'b1, 3'd7},
      {8'h81, 4'd1, 1'b1, 3'd7},
      {8'h16, 4'd0, 1'b1, 3'd4},
      {8'h16, 4'd5, 1'b0, 3'd0},
      {8'h16, 4'd4, 1'b1, 3'd4},
      {8'h0C, 4'd3, 1'b1, 3'd3},
      {8'hFF, 4'd8, 1'b0, 3'd0},
      {8'hFF, 4'd7, 1'b1, 3'd7}
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_irq(input int k);
      irq_in[k] = 1'b1;
      step(1);
      irq_in[k] = 1'b0;
   endtask

   task automatic strobe_gie;
      gie_set = 1'b1; step(1); gie_set = 1'b0;
   endtask

   task automatic strobe_ack;
      ack = 1'b1; step(1); ack = 1'b0;
   endtask

   task automatic clear_line(input int k);
      pend_clr[k] = 1'b1; step(1); pend_clr[k] = 1'b0;
   endtask

   task automatic expect_idle(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         step(1);
         chk(req, take, 0);
      end
   endtask

   task automatic finish_run;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R11 reset state
      chk("R11 take", take, 0);
      chk("R11 gie", gie, 0);
      chk("R11 thr", cur_thr, 0);
      chk("R11 depth", depth, 0);
      chk("R11 pending", pending, 0);
      chk("R11 valid", irq_valid, 0);

      for (int k = 0; k < N; k++) begin
         vec_wr = 1'b1; vec_sel = 3'(k); vec_wdata = 16'h1000 + 16'(k * 16);
         step(1);
      end
      vec_wr = 1'b0;

      // R1 / R5 / R10 pick table, enable stays clear
      for (int v = 0; v < 10; v++) begin
         irq_in = PICK_VEC[v][15:8];
         thr_wr = 1'b1; thr_wdata = PICK_VEC[v][7:4];
         step(1);
         thr_wr = 1'b0;
         chk("R1 R5 R10 valid", irq_valid, PICK_VEC[v][3]);
         chk("R1 R10 index", irq_idx, PICK_VEC[v][2:0]);
         irq_in = '0; pend_clr = '1;
         step(1);
         pend_clr = '0;
      end
      thr_wr = 1'b1; thr_wdata = 4'd0; step(1); thr_wr = 1'b0;

      // R6 sticky edge while masked, R3 no take while disabled
      pulse_irq(6);
      expect_idle("R3 disabled", 3);
      chk("R6 sticky", pending[6], 1);
      clear_line(6);
      chk("R6 cleared", pending[6], 0);
      irq_in[2] = 1'b1; step(1);
      chk("R6 level high", pending[2], 1);
      irq_in[2] = 1'b0; step(1);
      chk("R6 level low", pending[2], 0);

      // R2 R4 first take
      strobe_gie();
      pulse_irq(5);
      step(1);
      chk("R3 take", take, 1);
      chk("R2 vector", vec_addr, 16'h1050);
      chk("R4 gie", gie, 0);
      chk("R4 thr", cur_thr, 6);
      chk("R7 depth1", depth, 1);
      step(1);
      chk("R9 pulse", take, 0);

      // R9 no take before ack, then nested take
      clear_line(5);
      strobe_gie();
      pulse_irq(7);
      expect_idle("R9 wait ack", 3);
      strobe_ack();
      step(1);
      chk("R7 nest take", take, 1);
      chk("R2 nest vector", vec_addr, 16'h1070);
      chk("R7 depth2", depth, 2);
      chk("R4 thr8", cur_thr, 8);

      strobe_ack();
      clear_line(7);
      strobe_gie();
      irq_in[3] = 1'b1;
      expect_idle("R5 below thr", 3);
      chk("R10 valid", irq_valid, 0);
      chk("R10 index", irq_idx, 0);

      // R7 returns
      ret = 1'b1; step(1); ret = 1'b0;
      chk("R7 pop thr", cur_thr, 6);
      chk("R7 pop gie", gie, 1);
      chk("R7 pop depth", depth, 1);
      expect_idle("R5 still masked", 1);
      ret = 1'b1; step(1); ret = 1'b0;
      chk("R7 pop thr0", cur_thr, 0);
      chk("R7 depth0", depth, 0);
      step(1);
      chk("R1 level take", take, 1);
      chk("R2 level vector", vec_addr, 16'h1030);
      strobe_ack();
      irq_in[3] = 1'b0;
      ret = 1'b1; step(1); ret = 1'b0;
      chk("R7 back gie", gie, 1);

      // R8 stack full
      pulse_irq(4); step(1);
      chk("R8 take4", take, 1);
      strobe_ack(); clear_line(4); strobe_gie();
      pulse_irq(5); step(1);
      chk("R8 take5", take, 1);
      strobe_ack(); clear_line(5); strobe_gie();
      pulse_irq(7);
      expect_idle("R8 full", 3);
      chk("R8 depth", depth, 2);
      chk("R8 valid", irq_valid, 1);
      ret = 1'b1; step(1); ret = 1'b0;
      chk("R8 after pop", depth, 1);
      step(1);
      chk("R8 take7", take, 1);
      chk("R8 vector", vec_addr, 16'h1070);
      strobe_ack(); clear_line(7);
      ret = 1'b1; step(1); ret = 1'b0;
      ret = 1'b1; step(1); ret = 1'b0;
      chk("R7 empty", depth, 0);
      ret = 1'b1; step(1); ret = 1'b0;
      chk("R7 underflow depth", depth, 0);
      chk("R7 underflow thr", cur_thr, 0);
      chk("R7 underflow gie", gie, 1);

      finish_run();
   end
endmodule